// File: doc/BRIEF.md
# Timebase and Decrementer Timer

This block keeps two free-running time counters for a processor core: a 64-bit timebase that counts up and a 32-bit decrementer that counts down. A single prescaler divides the processor clock and drives both counters. It emits one tick every R cycles, where R is a programmable ratio. When the ratio is reprogrammed, the partial interval already counted is kept and counts toward the next tick.

Software can load each 32-bit half of the timebase on its own and can load the decrementer. Both counters are always readable on output ports. When a tick moves the decrementer from zero to all-ones, the block raises `dec_irq` for exactly one cycle. The pending-interrupt logic uses this pulse to set its decrementer pending bit (mask 0x2). All control and status pins are plain level signals with no flow control. A write strobe takes effect at the clock edge where it is sampled high, and it never stalls.

Top module: `tbdec_top`

## Requirements
- R1: While reset is low, and after it is released, the outputs start at `tb_rd` = 0, `dec_rd` = 0xFFFFFFFF and `dec_irq` = 0, with the prescaler remainder cleared and the ratio at its reset value.
- R2: With an effective ratio R, the timebase advances by one and the decrementer falls by one on the same clock edge, once every R cycles.
- R3: A programmed ratio of 0 behaves as a ratio of 1, so a tick occurs on every cycle.
- R4: Writing a new ratio keeps the prescaler remainder. If the remainder already reaches the new ratio, the next cycle ticks.
- R5: A tick that takes the decrementer from 0 to 0xFFFFFFFF raises `dec_irq` for exactly one cycle. That cycle is the one in which `dec_rd` first reads 0xFFFFFFFF.
- R6: A tick that takes the decrementer from 1 to 0 does not raise `dec_irq`.
- R7: `dec_we` loads `wdata` into the decrementer and wins over a tick in the same cycle. The write itself never raises `dec_irq`, even when the old value was 0.
- R8: `tbl_we` loads `wdata` into timebase bits 31:0 and `tbu_we` loads it into bits 63:32. In a cycle with either strobe, the timebase does not advance on a tick, and a half that is not written keeps its value.
- R9: The timebase wraps from all-ones to 0 on a tick and gives no other indication.
- R10: `ratio_we` loads `ratio_wdata`, and the new ratio governs tick decisions from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_we | input | 1 | Load the timer ratio |
| ratio_wdata | input | RATIO_W (8) | New timer ratio; 0 behaves as 1 |
| tbl_we | input | 1 | Load the lower timebase half from `wdata` |
| tbu_we | input | 1 | Load the upper timebase half from `wdata` |
| dec_we | input | 1 | Load the decrementer from `wdata` |
| wdata | input | 32 | Shared write data for the counters |
| tb_rd | output | 64 | Current timebase value |
| dec_rd | output | 32 | Current decrementer value |
| dec_irq | output | 1 | One-cycle pulse when the decrementer wraps past zero |

## Verification
The assertions assume that every write strobe and data input holds a known 0 or 1 value once reset is released. They also assume that the effective ratio is at least one, which the block enforces itself. Under these assumptions, two wraps can never come on back-to-back cycles, and a counter can only step or be loaded. The bench drives every input to a defined value on the falling clock edge. It keeps random ratios in the range 0 to 7 and random decrementer loads in the range 0 to 5, so that wraps, coincident writes and ratio changes in the middle of an interval all occur often within the run.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;
  localparam int unsigned DEF_TB_W    = 64;
  localparam int unsigned DEF_DEC_W   = 32;
  localparam int unsigned DEF_RATIO_W = 8;

  // Which halves of the timebase a write touches
  typedef struct packed {
    logic hi;
    logic lo;
  } half_we_t;
endpackage

// File: rtl/tbdec_prescale.sv
module tbdec_prescale #(
  parameter int unsigned RATIO_W     = tbdec_pkg::DEF_RATIO_W,
  parameter int unsigned RESET_RATIO = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ratio_we,
  input  logic [RATIO_W-1:0] ratio_wdata,
  output logic               tick
);
  localparam int unsigned EXT_W = RATIO_W + 1;

  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] frac_q;
  logic [EXT_W-1:0]   eff_ratio;
  logic [EXT_W-1:0]   frac_next;

  // A ratio of zero is treated as one
  always_comb begin
    eff_ratio = {1'b0, ratio_q};
    if (ratio_q == '0) eff_ratio = EXT_W'(1);
    frac_next = {1'b0, frac_q} + EXT_W'(1);
    tick      = (frac_next >= eff_ratio);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RATIO_W'(RESET_RATIO);
      frac_q  <= '0;
    end else begin
      if (ratio_we) ratio_q <= ratio_wdata;
      // The remainder is not cleared by a ratio write
      if (tick) frac_q <= '0;
      else      frac_q <= frac_next[RATIO_W-1:0];
    end
  end
endmodule

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
  parameter int unsigned TB_W = tbdec_pkg::DEF_TB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  tbdec_pkg::half_we_t half_we,
  input  logic [TB_W/2-1:0]  wdata,
  output logic [TB_W-1:0]    count
);
  localparam int unsigned HALF_W = TB_W / 2;

  logic [TB_W-1:0] count_q;
  logic [TB_W-1:0] stepped;
  logic [1:0]      we_vec;

  assign stepped = count_q + TB_W'(1);
  assign we_vec  = {half_we.hi, half_we.lo};

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        count_q[h*HALF_W +: HALF_W] <= '0;
      end else if (we_vec[h]) begin
        count_q[h*HALF_W +: HALF_W] <= wdata;
      end else if (tick && (we_vec == 2'b00)) begin
        count_q[h*HALF_W +: HALF_W] <= stepped[h*HALF_W +: HALF_W];
      end
    end
  end

  assign count = count_q;
endmodule

// File: rtl/tbdec_decr.sv
module tbdec_decr #(
  parameter int unsigned DEC_W = tbdec_pkg::DEF_DEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [DEC_W-1:0] wdata,
  output logic [DEC_W-1:0] count,
  output logic             wrap
);
  logic [DEC_W-1:0] count_q;
  logic             wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
      wrap_q  <= 1'b0;
    end else if (load) begin
      count_q <= wdata;
      wrap_q  <= 1'b0;
    end else if (tick) begin
      count_q <= count_q - DEC_W'(1);
      wrap_q  <= (count_q == '0);
    end else begin
      wrap_q  <= 1'b0;
    end
  end

  assign count = count_q;
  assign wrap  = wrap_q;
endmodule

// File: rtl/tbdec_top.sv
module tbdec_top #(
  parameter int unsigned TB_W        = tbdec_pkg::DEF_TB_W,
  parameter int unsigned DEC_W       = tbdec_pkg::DEF_DEC_W,
  parameter int unsigned RATIO_W     = tbdec_pkg::DEF_RATIO_W,
  parameter int unsigned RESET_RATIO = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ratio_we,
  input  logic [RATIO_W-1:0] ratio_wdata,
  input  logic               tbl_we,
  input  logic               tbu_we,
  input  logic               dec_we,
  input  logic [DEC_W-1:0]   wdata,
  output logic [TB_W-1:0]    tb_rd,
  output logic [DEC_W-1:0]   dec_rd,
  output logic               dec_irq
);
  localparam int unsigned HALF_W = TB_W / 2;

  logic                tick;
  tbdec_pkg::half_we_t tb_we;

  assign tb_we.lo = tbl_we;
  assign tb_we.hi = tbu_we;

  tbdec_prescale #(.RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)) pre_i (
    .clk(clk), .rst_n(rst_n), .ratio_we(ratio_we),
    .ratio_wdata(ratio_wdata), .tick(tick)
  );

  tbdec_timebase #(.TB_W(TB_W)) tb_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .half_we(tb_we),
    .wdata(HALF_W'(wdata)), .count(tb_rd)
  );

  tbdec_decr #(.DEC_W(DEC_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(dec_we),
    .wdata(wdata), .count(dec_rd), .wrap(dec_irq)
  );
endmodule

// File: rtl/tbdec_chk.sv
module tbdec_chk #(
  parameter int unsigned TB_W  = 64,
  parameter int unsigned DEC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tbl_we,
  input logic             tbu_we,
  input logic             dec_we,
  input logic [TB_W-1:0]  tb_rd,
  input logic [DEC_W-1:0] dec_rd,
  input logic             dec_irq
);
  // R5: the pulse coincides with the all-ones value
  p_irq_allones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_irq |-> (dec_rd == {DEC_W{1'b1}}));

  // R5: the pulse comes only from a count that was zero
  p_irq_from_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_irq |-> ($past(dec_rd) == '0));

  // R5: the pulse lasts a single cycle
  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_irq |=> !dec_irq);

  // R7: a load never raises the pulse
  p_load_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_we |=> !dec_irq);

  // R2: without a load the decrementer only steps down by one
  p_dec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(dec_we) && (dec_rd != $past(dec_rd))) |-> (dec_rd == $past(dec_rd) - DEC_W'(1)));

  // R9: without a write the timebase only steps up by one, wrapping silently
  p_tb_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tbl_we || tbu_we) && (tb_rd != $past(tb_rd))) |-> (tb_rd == $past(tb_rd) + TB_W'(1)));

  // R2: both counters move on the same edge when nothing is written
  p_lockstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tbl_we || tbu_we || dec_we) && (tb_rd != $past(tb_rd))) |-> (dec_rd != $past(dec_rd)));
endmodule

bind tbdec_top tbdec_chk #(.TB_W(TB_W), .DEC_W(DEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbu_we(tbu_we), .dec_we(dec_we),
  .tb_rd(tb_rd), .dec_rd(dec_rd), .dec_irq(dec_irq)
);

// File: tb/tbdec_top_tb_top.sv
module tbdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ratio_we = 1'b0;
  logic [7:0]  ratio_wdata = '0;
  logic        tbl_we = 1'b0, tbu_we = 1'b0, dec_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [63:0] tb_rd;
  logic [31:0] dec_rd;
  logic        dec_irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [7:0]  m_ratio, m_frac;
  logic [63:0] m_tb;
  logic [31:0] m_dec;
  logic        m_irq;

  always #2 clk = ~clk;

  tbdec_top dut_i (
    .clk(clk), .rst_n(rst_n), .ratio_we(ratio_we), .ratio_wdata(ratio_wdata),
    .tbl_we(tbl_we), .tbu_we(tbu_we), .dec_we(dec_we), .wdata(wdata),
    .tb_rd(tb_rd), .dec_rd(dec_rd), .dec_irq(dec_irq)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, "tb", tb_rd, m_tb);
    check(req, "dec", {32'h0, dec_rd}, {32'h0, m_dec});
    check(req, "irq", {63'h0, dec_irq}, {63'h0, m_irq});
  endtask

  function automatic logic ref_tick(logic [7:0] r, logic [7:0] f);
    logic [8:0] eff;
    eff = (r == 8'd0) ? 9'd1 : {1'b0, r};
    return ({1'b0, f} + 9'd1) >= eff;
  endfunction

  // drive at falling edge, advance one clock, update reference, compare
  task automatic step(string req, bit rwe, logic [7:0] rv, bit lwe, bit uwe, bit dwe, logic [31:0] wd);
    logic tk;
    logic [63:0] ntb;
    ratio_we = rwe; ratio_wdata = rv; tbl_we = lwe; tbu_we = uwe; dec_we = dwe; wdata = wd;
    tk  = ref_tick(m_ratio, m_frac);
    ntb = m_tb;
    if (lwe) ntb[31:0]  = wd;
    if (uwe) ntb[63:32] = wd;
    if (!lwe && !uwe && tk) ntb = m_tb + 64'd1;
    @(posedge clk);
    @(negedge clk);
    m_frac = tk ? 8'd0 : m_frac + 8'd1;
    if (rwe) m_ratio = rv;
    m_tb = ntb;
    if (dwe) begin m_dec = wd; m_irq = 1'b0; end
    else if (tk) begin m_irq = (m_dec == 32'd0); m_dec = m_dec - 32'd1; end
    else m_irq = 1'b0;
    check_all(req);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) step(req, 0, 8'd0, 0, 0, 0, 32'd0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] t0;
    void'($urandom(32'd20240611));
    m_ratio = 8'd1; m_frac = 8'd0; m_tb = '0; m_dec = 32'hFFFF_FFFF; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    // default ratio 1: one tick already happened after release
    m_tb = 64'd1; m_dec = 32'hFFFF_FFFE;
    check_all("R1");

    // R2: ratio 3
    step("R10", 1, 8'd3, 0, 0, 0, 0);
    idle("R2", 9);
    t0 = m_tb;
    idle("R2", 6);
    check("R2", "tb two ticks in six cycles", m_tb - t0, 64'd2);

    // R3: ratio 0 ticks every cycle
    step("R3", 1, 8'd0, 0, 0, 0, 0);
    t0 = tb_rd;
    idle("R3", 5);
    check("R3", "tb delta", tb_rd - t0, 64'd5);

    // R6 / R5: count down through zero at ratio 1
    step("R7", 1, 8'd1, 0, 0, 1, 32'd2);
    step("R6", 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0);
    check("R6", "dec at zero", {32'h0, dec_rd}, 64'd0);
    check("R6", "no irq at zero", {63'h0, dec_irq}, 64'd0);
    step("R5", 0, 0, 0, 0, 0, 0);
    check("R5", "irq on wrap", {63'h0, dec_irq}, 64'd1);
    check("R5", "dec all ones", {32'h0, dec_rd}, 64'hFFFF_FFFF);
    step("R5", 0, 0, 0, 0, 0, 0);
    check("R5", "irq one cycle", {63'h0, dec_irq}, 64'd0);

    // R7: load zero over a tick while at zero, then wrap
    step("R7", 0, 0, 0, 0, 1, 32'd0);
    step("R7", 0, 0, 0, 0, 1, 32'd0);
    check("R7", "load wins, no irq", {31'h0, dec_irq, dec_rd}, 64'd0);
    step("R7", 0, 0, 0, 0, 0, 0);
    check("R7", "wrap after load", {63'h0, dec_irq}, 64'd1);

    // R8: halves written on their own
    step("R8", 0, 0, 1, 0, 0, 32'h1234_5678);
    step("R8", 0, 0, 0, 1, 0, 32'hCAFE_0001);
    check("R8", "tb halves", tb_rd, 64'hCAFE_0001_1234_5678);

    // R9: silent wrap
    step("R9", 0, 0, 1, 1, 0, 32'hFFFF_FFFF);
    step("R9", 0, 0, 0, 0, 0, 0);
    check("R9", "tb wrap", tb_rd, 64'd0);

    // R4: remainder kept across a ratio change
    step("R4", 1, 8'd200, 0, 0, 0, 0);
    idle("R4", 6);
    t0 = tb_rd;
    step("R4", 1, 8'd3, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0);
    check("R4", "tick right after shrink", tb_rd - t0, 64'd1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit rwe, lwe, uwe, dwe;
      logic [31:0] wd;
      rwe = ($urandom % 64) == 0;
      lwe = ($urandom % 64) == 0;
      uwe = ($urandom % 64) == 0;
      dwe = ($urandom % 24) == 0;
      wd  = (lwe || uwe) ? (($urandom % 2) ? 32'hFFFF_FFFF : $urandom) : ($urandom % 6);
      step("R2", rwe, 8'($urandom % 8), lwe, uwe, dwe, wd);
    end
    finish_run();
  end
endmodule